// File: doc/BRIEF.md
# Supply Voltage Detector Event Line

This block compares a digitized supply-voltage sample with one of eight programmable thresholds and turns threshold crossings into interrupt and event requests. A 3-bit level code selects the threshold. The threshold values come from a computed table, `BASE + code * STEP`. The compare result passes through a two-stage synchronizer and is then shown as a live status flag. The block detects upward and downward transitions of that flag, and the routing configuration decides what each transition does.

Routing is a set of four independent enables: upward crossing, downward crossing, interrupt mode and event mode. A configuration write replaces the whole set at once, so any enable left out of a write is switched off. In interrupt mode a qualifying crossing sets a sticky pending flag, and software must clear that flag with a strobe. In event mode the same crossing produces a single-cycle pulse that does not touch the pending flag. The detector is gated off while its enable is low or while the system signals standby.

Top module: `vmon_evtline`

## Requirements
- R1: After reset, `above`, `pending`, `irq` and `evt` are 0 and all routing enables are off.
- R2: The threshold for level code c (0..7) is 64 + 16*c with the defaults. `above` is 1 when `sample >= threshold` and 0 otherwise, and it follows a change of `sample` on the third rising clock edge after that change.
- R3: While `sample` is held steady, the block raises no `evt` and does not set `pending`.
- R4: An upward transition of `above` with upward routing and interrupt mode enabled sets `pending` and `irq` on the clock edge after `above` rises.
- R5: A downward transition of `above` with downward routing and interrupt mode enabled sets `pending` and `irq` on the clock edge after `above` falls. A transition whose direction is not enabled has no effect.
- R6: When both directions are enabled, both an upward and a downward transition produce requests.
- R7: In event mode a qualifying transition drives `evt` high for exactly one cycle, in the same cycle that `pending` would be set. Event mode alone never sets `pending`.
- R8: `pending` stays set until `pend_clr` is high at a clock edge. If a new qualifying transition arrives in the same cycle as `pend_clr`, `pending` stays set.
- R9: A write with `cfg_wr` high loads all four enables from the `cfg_*` inputs at once. An enable that was on before and is 0 in the write is off afterwards.
- R10: When `det_en` is low or `standby` is high, `above` reads 0 from the next clock edge onward, and that forced drop is not reported as a crossing.
- R11: `irq` equals `pending` while interrupt mode is enabled. It is 0 from the configuration write that turns interrupt mode off, and `pending` is unaffected by that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample | input | 8 | Digitized supply-voltage sample |
| level | input | 3 | Threshold level code |
| det_en | input | 1 | Detector enable |
| standby | input | 1 | Standby indication; gates the detector off |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rise | input | 1 | Upward-crossing enable, loaded on a write |
| cfg_fall | input | 1 | Downward-crossing enable, loaded on a write |
| cfg_irq | input | 1 | Interrupt-mode enable, loaded on a write |
| cfg_evt | input | 1 | Event-mode enable, loaded on a write |
| pend_clr | input | 1 | Pending-flag clear strobe |
| above | output | 1 | Live status: sample at or above the threshold |
| pending | output | 1 | Sticky interrupt pending flag |
| irq | output | 1 | Interrupt request |
| evt | output | 1 | One-cycle event pulse |

## Verification
The bench tests every level code with a sample one step below the threshold and a sample exactly at it. A design with an off-by-one compare or a wrong table step fails on the boundary values. It also runs all sixteen combinations of the routing enables, each with an upward and a downward crossing. A design that routes the wrong direction, lets event mode set `pending`, or stretches `evt` beyond one cycle fails there. Separate tests cover:
- a second configuration write that drops an earlier enable; a design that ORs in the new enables keeps reacting to the old direction.
- a clear that lands in the same cycle as a new crossing; a design that gives the clear priority loses that request.
- turning the detector off while the status is high; a design that lets the forced drop through reports a false falling crossing.

// File: rtl/vmon_pkg.sv
package vmon_pkg;
  // Routing enables for the event line.
  typedef struct packed {
    logic rise;
    logic fall;
    logic irq;
    logic evt;
  } route_t;

  localparam route_t ROUTE_OFF = '{rise: 1'b0, fall: 1'b0, irq: 1'b0, evt: 1'b0};
endpackage

// File: rtl/vmon_level_cmp.sv
module vmon_level_cmp #(
  parameter int SAMPLE_W = 8,
  parameter int LEVEL_W  = 3,
  parameter int BASE     = 64,
  parameter int STEP     = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                gate,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [LEVEL_W-1:0]  level,
  output logic                cmp_q
);
  localparam int NUM_LEVELS = 1 << LEVEL_W;

  logic [SAMPLE_W-1:0] thr_tab [NUM_LEVELS];

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_thr
    assign thr_tab[g] = SAMPLE_W'(BASE + g * STEP);
  end

  always_ff @(posedge clk) begin
    if (rst)       cmp_q <= 1'b0;
    else if (!gate) cmp_q <= 1'b0;
    else           cmp_q <= (sample >= thr_tab[level]);
  end

  AST_CMP_GATED: assert property (@(posedge clk) disable iff (rst)
    !gate |=> !cmp_q); // R10
endmodule

// File: rtl/vmon_sync_edge.sv
module vmon_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  input  logic d,
  output logic above,
  output logic rise,
  output logic fall
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || !gate) sh <= '0;
    else              sh <= {sh[SH_W-2:0], d};
  end

  assign above = sh[SYNC_STAGES-1];
  assign rise  = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  assign fall  = ~sh[SYNC_STAGES-1] & sh[SYNC_STAGES];

  AST_STATUS_GATED: assert property (@(posedge clk) disable iff (rst)
    !gate |=> !above && !fall); // R10
endmodule

// File: rtl/vmon_route.sv
module vmon_route
  import vmon_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   cfg_wr,
  input  route_t cfg_i,
  input  logic   rise_i,
  input  logic   fall_i,
  input  logic   pend_clr,
  output logic   pending,
  output logic   irq,
  output logic   evt
);
  route_t route_q, route_n;
  logic   hit, pend_n;
  logic   pending_q, irq_q, evt_q;

  always_comb begin
    hit     = (rise_i & route_q.rise) | (fall_i & route_q.fall);
    route_n = cfg_wr ? cfg_i : route_q;
    pend_n  = (hit & route_q.irq) | (pending_q & ~pend_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q   <= ROUTE_OFF;
      pending_q <= 1'b0;
      irq_q     <= 1'b0;
      evt_q     <= 1'b0;
    end else begin
      route_q   <= route_n;
      pending_q <= pend_n;
      irq_q     <= pend_n & route_n.irq;
      evt_q     <= hit & route_q.evt;
    end
  end

  assign pending = pending_q;
  assign irq     = irq_q;
  assign evt     = evt_q;

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    pending_q && !pend_clr |=> pending_q); // R8
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> pending_q); // R11
  AST_EVT_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
    evt_q |-> $past(route_q.evt)); // R7
  AST_PEND_NEEDS_IRQ_MODE: assert property (@(posedge clk) disable iff (rst)
    $rose(pending_q) |-> $past(route_q.irq)); // R4
endmodule

// File: rtl/vmon_evtline.sv
module vmon_evtline
  import vmon_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int LEVEL_W     = 3,
  parameter int BASE        = 64,
  parameter int STEP        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [LEVEL_W-1:0]  level,
  input  logic                det_en,
  input  logic                standby,
  input  logic                cfg_wr,
  input  logic                cfg_rise,
  input  logic                cfg_fall,
  input  logic                cfg_irq,
  input  logic                cfg_evt,
  input  logic                pend_clr,
  output logic                above,
  output logic                pending,
  output logic                irq,
  output logic                evt
);
  logic   gate, cmp_q, rise, fall;
  route_t cfg;

  assign gate = det_en & ~standby;
  assign cfg  = '{rise: cfg_rise, fall: cfg_fall, irq: cfg_irq, evt: cfg_evt};

  vmon_level_cmp #(
    .SAMPLE_W(SAMPLE_W), .LEVEL_W(LEVEL_W), .BASE(BASE), .STEP(STEP)
  ) u_cmp (
    .clk(clk), .rst(rst), .gate(gate), .sample(sample), .level(level), .cmp_q(cmp_q)
  );

  vmon_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .gate(gate), .d(cmp_q),
    .above(above), .rise(rise), .fall(fall)
  );

  vmon_route u_route (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_i(cfg),
    .rise_i(rise), .fall_i(fall), .pend_clr(pend_clr),
    .pending(pending), .irq(irq), .evt(evt)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !pending && !irq && !evt && !above); // R1
endmodule

// File: tb/vmon_evtline_bench.sv
module vmon_evtline_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sample = '0;
  logic [2:0] level = '0;
  logic       det_en = 1'b1, standby = 1'b0;
  logic       cfg_wr = 1'b0, cfg_rise = 1'b0, cfg_fall = 1'b0, cfg_irq = 1'b0, cfg_evt = 1'b0;
  logic       pend_clr = 1'b0;
  logic       above, pending, irq, evt;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  vmon_evtline u_vmon_evtline (
    .clk(clk), .rst(rst), .sample(sample), .level(level), .det_en(det_en),
    .standby(standby), .cfg_wr(cfg_wr), .cfg_rise(cfg_rise), .cfg_fall(cfg_fall),
    .cfg_irq(cfg_irq), .cfg_evt(cfg_evt), .pend_clr(pend_clr),
    .above(above), .pending(pending), .irq(irq), .evt(evt)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic configure(input logic r, input logic f, input logic i, input logic e);
    cfg_rise = r; cfg_fall = f; cfg_irq = i; cfg_evt = e; cfg_wr = 1'b1;
    step(1);
    cfg_wr = 1'b0;
  endtask

  task automatic clear_pend();
    pend_clr = 1'b1;
    step(1);
    pend_clr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int evt_seen;
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk("R1 above", above, 1'b0);
    chk("R1 pending", pending, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 evt", evt, 1'b0);

    // R2 threshold sweep with routing off
    for (int c = 0; c < 8; c++) begin
      int thr;
      thr = 64 + 16 * c;
      level = 3'(c);
      sample = 8'(thr - 1);
      step(3);
      chk("R2 below", above, 1'b0);
      sample = 8'(thr);
      step(2);
      chk("R2 latency", above, 1'b0);
      step(1);
      chk("R2 at threshold", above, 1'b1);
    end
    sample = 8'd0; level = 3'd0;
    step(4);

    // R4 R5 R6 R7 all routing combinations
    for (int m = 0; m < 16; m++) begin
      logic r, f, i, e;
      {r, f, i, e} = 4'(m);
      configure(r, f, i, e);
      clear_pend();
      sample = 8'd200;
      step(3);
      chk("R2 rise status", above, 1'b1);
      chk("R4 no early evt", evt, 1'b0);
      step(1);
      chk("R7 rise evt", evt, r & e);
      chk("R4 rise pending", pending, r & i);
      chk("R4 rise irq", irq, r & i);
      step(1);
      chk("R7 evt one cycle", evt, 1'b0);
      clear_pend();
      chk("R8 cleared", pending, 1'b0);
      sample = 8'd0;
      step(4);
      chk("R7 fall evt", evt, f & e);
      chk("R5 fall pending", pending, f & i);
      chk("R6 fall irq", irq, f & i);
      step(1);
      chk("R7 evt one cycle fall", evt, 1'b0);
      clear_pend();
    end

    // R3 steady input
    configure(1'b1, 1'b1, 1'b1, 1'b1);
    sample = 8'd150;
    step(6);
    clear_pend();
    evt_seen = 0;
    for (int k = 0; k < 20; k++) begin
      step(1);
      if (evt || pending) evt_seen++;
    end
    chk("R3 steady no request", evt_seen != 0, 1'b0);

    // R8 sticky and set-wins-over-clear
    sample = 8'd0;
    step(8);
    clear_pend();
    configure(1'b1, 1'b0, 1'b1, 1'b0);
    sample = 8'd200;
    step(10);
    chk("R8 sticky", pending, 1'b1);
    clear_pend();
    sample = 8'd0;
    step(6);
    sample = 8'd200;
    step(3);
    pend_clr = 1'b1;
    step(1);
    pend_clr = 1'b0;
    chk("R8 set wins", pending, 1'b1);

    // R11 interrupt mode off keeps pending
    configure(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R11 irq off", irq, 1'b0);
    chk("R11 pending kept", pending, 1'b1);
    clear_pend();

    // R9 reconfigure drops old enable
    sample = 8'd0;
    step(6);
    configure(1'b1, 1'b0, 1'b1, 1'b1);
    configure(1'b0, 1'b1, 1'b1, 1'b0);
    sample = 8'd200;
    step(6);
    chk("R9 old rise dropped", pending, 1'b0);
    sample = 8'd0;
    step(4);
    chk("R9 new fall active", pending, 1'b1);
    clear_pend();

    // R10 gating: enable low, then standby
    configure(1'b1, 1'b1, 1'b1, 1'b1);
    det_en = 1'b0;
    sample = 8'd200;
    step(6);
    chk("R10 disabled above", above, 1'b0);
    chk("R10 disabled pending", pending, 1'b0);
    det_en = 1'b1;
    step(6);
    clear_pend();
    chk("R10 reenabled above", above, 1'b1);
    standby = 1'b1;
    step(1);
    chk("R10 standby above", above, 1'b0);
    step(5);
    chk("R10 standby no fall", pending, 1'b0);
    chk("R10 standby no evt", evt, 1'b0);
    standby = 1'b0;
    step(6);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule